// File: doc/BRIEF.md
# Serial-to-Parallel LED Shift Controller

This block drives an external chain of serial-in, parallel-out shift registers arranged as up to three 8-bit groups. Software programs it through a small 32-bit register bus. At the start of a frame the block takes a snapshot of a 24-bit output image. It then shifts that image onto a data line with a shift clock and closes the frame with a store strobe, which moves the chain's contents onto its parallel outputs.

Each of the eight lowest output bits can be driven either by software or by a live hardware status input. These inputs are a two-bit modem link indicator and two 3-bit PHY status buses, and a per-bit enable picks the source. A frame starts in one of two ways. Software can request one by writing the update bit. Otherwise a refresh timer restarts the frame periodically, at one of four low rates. A configuration bit selects the shift-clock edge on which the external chain captures data.

Top module: `ledshift_ctrl`

## Requirements
- R1: After reset, register 0x00 reads 0x8000_0000 and registers 0x04, 0x08, 0x0C and 0x10 read 0. Every register reads back the last value written to it, one cycle after a read strobe.
- R2: A frame shifts 8 × h bits, where h is the position (1..3) of the highest set bit of the group-enable field at register 0x04 bits [2:0]. If that field is 0, an update request sends no frame.
- R3: Bits are sent most significant first. Image bits above 7 come from register 0x08. Bit i of the low eight comes from a hardware input when its enable is set, and from register 0x08 otherwise. The hardware sources are: bits 1:0 from link inputs enabled by 0x00[25:24], bits 4:2 from PHY-A enabled by 0x00[29:27], and bits 7:5 from PHY-B enabled by 0x04[17:15].
- R4: With 0x00[26]=1 the shift clock idles high and the chain captures on its falling edge. With 0x00[26]=0 it idles low and the chain captures on its rising edge.
- R5: After the last bit the store strobe is high for exactly DIV system clocks. The shift clock stays at idle level during the strobe, and busy is high from the first bit until the strobe ends.
- R6: Writing 0x00 with bit 31 set requests one frame. Any number of requests arriving during a frame are merged into exactly one further frame.
- R7: While 0x04[31:30] is nonzero, frames repeat with a period of 20, 10, 5 or 4 × RATE_UNIT clocks for rate code 0x04[24:23] = 0, 1, 2 or 3 (2, 4, 8 and 10 Hz in ratio). Setting 0x04[31:30] back to 0 stops the repetition.
- R8: Without an update request or an active refresh timer, no frame is sent and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| link_sts | input | 2 | Modem link status inputs for image bits 1:0 |
| phy_a_sts | input | 3 | First PHY status bus for image bits 4:2 |
| phy_b_sts | input | 3 | Second PHY status bus for image bits 7:5 |
| ser_data | output | 1 | Serial data to the chain |
| ser_clk | output | 1 | Shift clock to the chain |
| ser_store | output | 1 | Store strobe to the chain |
| busy | output | 1 | Frame in progress |

## Verification
Faults in the bit-index counter or in the frame-length decode appear at the serial pins as a frame that is too short or too long, or as a frame shifted by one or more bits. The bench detects this at the next store strobe, about a hundred clocks after the trigger. A lost or duplicated pending request changes the frame count within two frame times. A wrong refresh-counter limit shows up as the wrong interval between consecutive store strobes, which is measured after the third automatic frame. A mixed-up ownership mux corrupts particular low-order bits of the captured word.

// File: rtl/ledshift_pkg.sv
package ledshift_pkg;
  localparam int GROUP_W   = 8;
  localparam int NUM_GROUP = 3;
  localparam int IMG_W     = GROUP_W * NUM_GROUP;
  localparam int IDX_W     = $clog2(IMG_W);
  localparam int LEN_W     = $clog2(IMG_W + 1);

  localparam logic [4:0] OFS_CTRL0 = 5'h00;
  localparam logic [4:0] OFS_CTRL1 = 5'h04;
  localparam logic [4:0] OFS_DATA0 = 5'h08;
  localparam logic [4:0] OFS_DATA1 = 5'h0C;
  localparam logic [4:0] OFS_ACC   = 5'h10;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STORE} ser_state_t;

  function automatic logic [1:0] top_group(input logic [2:0] en);
    if (en[2])      return 2'd3;
    else if (en[1]) return 2'd2;
    else if (en[0]) return 2'd1;
    else            return 2'd0;
  endfunction
endpackage

// File: rtl/ledshift_regs.sv
module ledshift_regs
  import ledshift_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [4:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctrl0,
  output logic [DW-1:0] ctrl1,
  output logic [DW-1:0] data0,
  output logic          upd_req
);
  logic [DW-1:0] data1, acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0   <= {1'b1, {(DW-1){1'b0}}};
      ctrl1   <= '0;
      data0   <= '0;
      data1   <= '0;
      acc     <= '0;
      upd_req <= 1'b0;
      rdata   <= '0;
    end else begin
      upd_req <= 1'b0;
      if (wr) begin
        case (addr)
          OFS_CTRL0: begin ctrl0 <= wdata; upd_req <= wdata[DW-1]; end
          OFS_CTRL1: ctrl1 <= wdata;
          OFS_DATA0: data0 <= wdata;
          OFS_DATA1: data1 <= wdata;
          OFS_ACC:   acc   <= wdata;
          default: ;
        endcase
      end
      if (rd) begin
        case (addr)
          OFS_CTRL0: rdata <= ctrl0;
          OFS_CTRL1: rdata <= ctrl1;
          OFS_DATA0: rdata <= data0;
          OFS_DATA1: rdata <= data1;
          OFS_ACC:   rdata <= acc;
          default:   rdata <= '0;
        endcase
      end
    end
  end

  // R6: a request pulse only follows a write to the first control register
  a_r6_req_from_write: assert property (@(posedge clk) disable iff (rst)
    upd_req |-> ($past(wr) && $past(addr) == OFS_CTRL0));
endmodule

// File: rtl/ledshift_timer.sv
module ledshift_timer #(
  parameter int RATE_UNIT = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int PER0 = 20 * RATE_UNIT;
  localparam int PER1 = 10 * RATE_UNIT;
  localparam int PER2 = 5 * RATE_UNIT;
  localparam int PER3 = 4 * RATE_UNIT;
  localparam int CW   = $clog2(PER0 + 1);

  logic [CW-1:0] cnt, last;

  always_comb begin
    case (rate)
      2'd0:    last = CW'(PER0 - 1);
      2'd1:    last = CW'(PER1 - 1);
      2'd2:    last = CW'(PER2 - 1);
      default: last = CW'(PER3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R7: refresh ticks are isolated single-cycle pulses
  a_r7_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ledshift_serializer.sv
module ledshift_serializer
  import ledshift_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IMG_W-1:0] image,
  input  logic [LEN_W-1:0] nbits,
  input  logic             edge_fall,
  output logic             sdo,
  output logic             sclk,
  output logic             sstore,
  output logic             busy
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;

  ser_state_t       st;
  logic             pend, fall_q;
  logic [PW-1:0]    ph;
  logic [IDX_W-1:0] bidx;
  logic [IMG_W-1:0] img;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; pend <= 1'b0; fall_q <= 1'b0; ph <= '0; bidx <= '0;
      img <= '0; sdo <= 1'b0; sclk <= 1'b0; sstore <= 1'b0; busy <= 1'b0;
    end else begin
      pend <= pend | req;
      case (st)
        S_IDLE: begin
          sclk <= edge_fall;
          sdo  <= 1'b0;
          ph   <= '0;
          if (pend) begin
            pend <= req;
            if (nbits != '0) begin
              img    <= image;
              fall_q <= edge_fall;
              bidx   <= IDX_W'(nbits - 1'b1);
              sdo    <= image[IDX_W'(nbits - 1'b1)];
              busy   <= 1'b1;
              st     <= S_SHIFT;
            end
          end
        end
        S_SHIFT: begin
          if (ph == PW'(DIV - 1)) begin
            ph   <= '0;
            sclk <= fall_q;
            if (bidx == '0) begin
              sstore <= 1'b1;
              st     <= S_STORE;
            end else begin
              bidx <= bidx - 1'b1;
              sdo  <= img[bidx - 1'b1];
            end
          end else begin
            ph <= ph + 1'b1;
            if (ph == PW'(HALF - 1)) sclk <= ~fall_q;
          end
        end
        default: begin
          if (ph == PW'(DIV - 1)) begin
            ph     <= '0;
            sstore <= 1'b0;
            busy   <= 1'b0;
            st     <= S_IDLE;
          end else begin
            ph <= ph + 1'b1;
          end
        end
      endcase
    end
  end

  // R5: the chain clock rests at its idle level while the strobe is high
  a_r5_store_clk_idle: assert property (@(posedge clk) disable iff (rst)
    sstore |-> (sclk == fall_q));
  // R5: the strobe lies inside the busy window
  a_r5_store_in_busy: assert property (@(posedge clk) disable iff (rst)
    sstore |-> busy);
  // R2: an empty group selection never starts a frame
  a_r2_empty_no_start: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && pend && nbits == '0 && !busy) |=> !busy);
  // R6: a request seen during a frame is kept for later
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (busy && st == S_SHIFT && req) |=> pend);
endmodule

// File: rtl/ledshift_ctrl.sv
module ledshift_ctrl
  import ledshift_pkg::*;
#(
  parameter int DIV       = 4,
  parameter int RATE_UNIT = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  link_sts,
  input  logic [2:0]  phy_a_sts,
  input  logic [2:0]  phy_b_sts,
  output logic        ser_data,
  output logic        ser_clk,
  output logic        ser_store,
  output logic        busy
);
  logic [31:0]      ctrl0, ctrl1, data0;
  logic             upd_req, tick;
  logic [IMG_W-1:0] image;
  logic [LEN_W-1:0] nbits;

  ledshift_regs #(.DW(32)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .ctrl0(ctrl0), .ctrl1(ctrl1),
    .data0(data0), .upd_req(upd_req));

  ledshift_timer #(.RATE_UNIT(RATE_UNIT)) u_timer (
    .clk(clk), .rst(rst), .en(|ctrl1[31:30]), .rate(ctrl1[24:23]), .tick(tick));

  always_comb begin
    image = data0[IMG_W-1:0];
    for (int i = 0; i < 2; i++)
      if (ctrl0[24+i]) image[i] = link_sts[i];
    for (int i = 0; i < 3; i++) begin
      if (ctrl0[27+i]) image[2+i] = phy_a_sts[i];
      if (ctrl1[15+i]) image[5+i] = phy_b_sts[i];
    end
    nbits = LEN_W'(top_group(ctrl1[2:0])) * LEN_W'(GROUP_W);
  end

  ledshift_serializer #(.DIV(DIV)) u_ser (
    .clk(clk), .rst(rst), .req(upd_req | tick), .image(image), .nbits(nbits),
    .edge_fall(ctrl0[26]), .sdo(ser_data), .sclk(ser_clk), .sstore(ser_store),
    .busy(busy));
endmodule

// File: tb/ledshift_ctrl_test.sv
module ledshift_ctrl_test;
  localparam int DIV = 4;
  localparam int UNIT = 50;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [1:0] link_sts = 0;
  logic [2:0] phy_a_sts = 0, phy_b_sts = 0;
  logic ser_data, ser_clk, ser_store, busy;

  always #2 clk = ~clk;

  ledshift_ctrl #(.DIV(DIV), .RATE_UNIT(UNIT)) uut (.*);

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit cfg_fall = 0;

  // port monitor
  logic [23:0] acc, frm_val;
  int acc_len, frm_len, frm_cnt, t_last, t_prev, store_run, store_len;
  logic p_clk, p_store, p_busy;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst) begin
      acc = 0; acc_len = 0; frm_cnt = 0; frm_val = 0; frm_len = 0;
      t_last = 0; t_prev = 0; store_run = 0; store_len = 0;
      p_clk = 0; p_store = 0; p_busy = 0;
    end else begin
      if (busy && !p_busy) begin acc = 0; acc_len = 0; end
      if (ser_clk != p_clk && ser_clk == !cfg_fall) begin
        acc = {acc[22:0], ser_data}; acc_len++;
      end
      if (ser_store && !p_store) begin
        frm_val = acc; frm_len = acc_len; frm_cnt++;
        t_prev = t_last; t_last = cyc; store_run = 1;
      end else if (ser_store) store_run++;
      if (!ser_store && p_store) store_len = store_run;
      p_clk = ser_clk; p_store = ser_store; p_busy = busy;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic wait_frames(input int target);
    for (int i = 0; i < 6000 && frm_cnt < target; i++) @(negedge clk);
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [23:0] exp_img(input logic [31:0] d, c0, c1,
      input logic [1:0] l, input logic [2:0] pa, pb);
    logic [23:0] m = d[23:0];
    for (int i = 0; i < 2; i++) if (c0[24+i]) m[i] = l[i];
    for (int i = 0; i < 3; i++) begin
      if (c0[27+i]) m[2+i] = pa[i];
      if (c1[15+i]) m[5+i] = pb[i];
    end
    return m;
  endfunction

  function automatic int exp_len(input logic [2:0] g);
    return g[2] ? 24 : g[1] ? 16 : g[0] ? 8 : 0;
  endfunction

  function automatic int exp_per(input int r);
    return (r == 0 ? 20 : r == 1 ? 10 : r == 2 ? 5 : 4) * UNIT;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, d, c0, c1;
    logic [23:0] e, msk;
    int n, len;
    void'($urandom(32'd20250));
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset values
    rd(5'h00, r); chk(r == 32'h8000_0000, "R1 ctrl0 reset", r, 32'h8000_0000);
    rd(5'h04, r); chk(r == 0, "R1 ctrl1 reset", r, 0);
    rd(5'h08, r); chk(r == 0, "R1 data0 reset", r, 0);
    rd(5'h0C, r); chk(r == 0, "R1 data1 reset", r, 0);
    rd(5'h10, r); chk(r == 0, "R1 acc reset", r, 0);
    // R8 idle after reset
    repeat (300) @(negedge clk);
    chk(frm_cnt == 0, "R8 no frame after reset", frm_cnt, 0);
    chk(!busy, "R8 busy low", busy, 0);
    chk(ser_clk == 0, "R4 idle level rising", ser_clk, 0);
    // R1 readback
    wr(5'h0C, 32'hA5C3_0F11); rd(5'h0C, r);
    chk(r == 32'hA5C3_0F11, "R1 data1 readback", r, 32'hA5C3_0F11);
    wr(5'h10, 32'h1234_5678); rd(5'h10, r);
    chk(r == 32'h1234_5678, "R1 acc readback", r, 32'h1234_5678);

    // random frames: R2 R3 R4 R5 R6
    for (int it = 0; it < 16; it++) begin
      d  = $urandom;
      c1 = ({29'd0, 3'($urandom_range(1, 7))}) | (32'($urandom_range(0, 7)) << 15);
      c0 = (32'($urandom_range(0, 7)) << 27) | (32'($urandom_range(0, 1)) << 26)
         | (32'($urandom_range(0, 3)) << 24);
      if (it == 0) begin d = 32'h00F0_0F5A; c1 = 32'h7; c0 = 0; end
      if (it == 1) begin d = 32'h0000_00C3; c1 = 32'h1 | (32'h7 << 15); c0 = (32'h7 << 27) | (32'h3 << 24) | (32'h1 << 26); end
      link_sts = 2'($urandom); phy_a_sts = 3'($urandom); phy_b_sts = 3'($urandom);
      wr(5'h04, c1); wr(5'h08, d);
      cfg_fall = c0[26];
      wr(5'h00, c0);
      rd(5'h00, r); chk(r == c0, "R1 ctrl0 readback", r, c0);
      chk(ser_clk == c0[26], "R4 idle level", ser_clk, c0[26]);
      n = frm_cnt;
      wr(5'h00, c0 | 32'h8000_0000);
      wait_frames(n + 1);
      len = exp_len(c1[2:0]);
      e = exp_img(d, c0, c1, link_sts, phy_a_sts, phy_b_sts);
      msk = 24'hFF_FFFF >> (24 - len);
      chk(frm_cnt == n + 1, "R6 one frame per request", frm_cnt, n + 1);
      chk(frm_len == len, "R2 frame length", frm_len, len);
      chk(frm_val == (e & msk), "R3 frame content", frm_val, e & msk);
      chk(store_len == DIV, "R5 strobe width", store_len, DIV);
      chk(!busy && ser_clk == c0[26], "R5 busy ends, clock idle", {busy, ser_clk}, {1'b0, c0[26]});
    end

    // R2 empty group selection
    cfg_fall = 0;
    wr(5'h04, 32'h0); n = frm_cnt;
    wr(5'h00, 32'h8000_0000);
    repeat (300) @(negedge clk);
    chk(frm_cnt == n && !busy, "R2 no frame when groups off", frm_cnt, n);

    // R6 merged pending requests
    wr(5'h04, 32'h7); n = frm_cnt;
    wr(5'h00, 32'h8000_0000);
    repeat (8) @(negedge clk);
    chk(busy, "R5 busy during frame", busy, 1);
    wr(5'h00, 32'h8000_0000); wr(5'h00, 32'h8000_0000); wr(5'h00, 32'h8000_0000);
    repeat (600) @(negedge clk);
    chk(frm_cnt == n + 2, "R6 requests merged", frm_cnt, n + 2);

    // R7 automatic refresh rates
    wr(5'h00, 32'h0);
    for (int rt = 0; rt < 4; rt++) begin
      n = frm_cnt;
      wr(5'h04, (32'h2 << 30) | (32'(rt) << 23) | 32'h7);
      wait_frames(n + 3);
      chk(t_last - t_prev == exp_per(rt), "R7 refresh period", t_last - t_prev, exp_per(rt));
      wr(5'h04, 32'h7);
      repeat (200) @(negedge clk);
    end
    n = frm_cnt;
    repeat (1500) @(negedge clk);
    chk(frm_cnt == n, "R7 refresh stops", frm_cnt, n);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule